// File: doc/BRIEF.md
# Microcoded Byte Processing Unit

This block is a small processing unit that runs a program from its own control store. An 8-bit data section holds eight working registers, a four-operation arithmetic unit, an input latch and an output latch. A control section steps through 18-bit microwords held in a 16-entry store. Each cycle, the current word either drives the data section or tests a condition and chooses the next address.

A program is written into the store through a dedicated write port while `start` is low, usually with reset held. After reset is released the sequencer begins at address 0. A program typically waits on `start`, pulls operands in through `din`, computes, latches results on `dout` and raises `done` from a microword.

Condition flags are not stored. A branch word also addresses the register file and selects an ALU operation through the bits it shares with the control format, so a branch tests the flags of the operation it names itself, in its own cycle.

Top module: `useq_core`

## Requirements
- R1: The register file holds 8 words of 8 bits. In one cycle it serves two reads, on the A and B addresses, and one write to the C address on the rising edge when the register-write strobe is 1.
- R2: The ALU opcode selects 00 = A+B, 01 = A-B, 10 = A xor B and 11 = A+1. The result goes to the output latch when the output-load strobe is 1.
- R3: The flags are: zero when the 8-bit result is 0, neg equal to result bit 7, and cy equal to the carry out of bit 7 for add and increment, the borrow (A < B) for subtract, and 0 for xor.
- R4: The register-file write data is the ALU result when the input-select bit is 0 and the input latch when it is 1.
- R5: The input latch loads `din` when the input-load strobe is 1. The output latch holds its value in every cycle without the output-load strobe.
- R6: Control word layout (bit 17 = 0): A address [16:14], B address [13:11], C address [10:8], opcode [7:6], register write [5], output load [4], input load [3], input select [2], done [1]. Bit 0 is unused.
- R7: Branch word layout (bit 17 = 1): condition [16:15] (00 start, 01 zero, 10 neg, 11 cy), required value [14], target [13:0]. On a match the microaddress loads target[3:0]. Otherwise, and after every control word, it increments, wrapping from 15 to 0.
- R8: While a branch word is current, the register write, output load, input load and `done` are all 0. Its bits [16:14], [13:11] and [7:6] still act as the A address, B address and opcode that produce the flags it tests.
- R9: A synchronous reset sets the microaddress to 0 and clears the input latch, the output latch and all eight registers. The control store is kept.
- R10: A store write to `cs_addr` takes effect on the clock edge when `cs_we` is 1 and `start` is 0. It is ignored while `start` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request, testable by branches; blocks store writes |
| din | input | 8 | Data input to the input latch |
| dout | output | 8 | Registered output latch |
| done | output | 1 | Done bit of the current control word |
| cs_we | input | 1 | Control store write enable |
| cs_addr | input | 4 | Control store write address |
| cs_wdata | input | 18 | Control store write data |

## Verification
The overlap that matters is a branch word that names an ALU operation and tests its flags in the cycle it is current, while its shared strobe bits must stay inert. The bench builds branch words whose register-write, output-load, input-load and done positions are all set. It fills the two operand registers so that each flag comes out both ways, and then checks in the branch cycle that `done` is 0. In the following cycle it checks that `dout` has not moved, and that `done` shows whether the target was taken or the word after the branch was reached.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // microword geometry; bit positions are decoded by the sequencer
    parameter int unsigned UW      = 18;
    parameter int unsigned RAW     = 3;
    parameter int unsigned MODE_B  = 17;
    parameter int unsigned COND_LO = 15;
    parameter int unsigned CVAL_B  = 14;
    parameter int unsigned RA_LO   = 14;
    parameter int unsigned RB_LO   = 11;
    parameter int unsigned WC_LO   = 8;
    parameter int unsigned OP_LO   = 6;
    parameter int unsigned LDRF_B  = 5;
    parameter int unsigned LDOUT_B = 4;
    parameter int unsigned LDIN_B  = 3;
    parameter int unsigned SEL_B   = 2;
    parameter int unsigned DONE_B  = 1;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_XOR = 2'b10,
        ALU_INC = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_START = 2'b00,
        CND_ZERO  = 2'b01,
        CND_NEG   = 2'b10,
        CND_CARRY = 2'b11
    } cond_e;

    typedef struct packed {
        logic [RAW-1:0] ra;
        logic [RAW-1:0] rb;
        logic [RAW-1:0] wc;
        alu_op_e        op;
        logic           ld_rf;
        logic           ld_out;
        logic           ld_in;
        logic           sel_in;
        logic           done;
    } uop_s;

endpackage

// File: rtl/useq_alu.sv
module useq_alu
    import useq_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] res,
    output logic          zero,
    output logic          neg,
    output logic          cy
);

    logic [DW:0] wide;

    always_comb begin
        case (op)
            ALU_ADD: wide = {1'b0, a} + {1'b0, b};
            ALU_SUB: wide = {1'b0, a} - {1'b0, b};
            ALU_XOR: wide = {1'b0, a ^ b};
            default: wide = {1'b0, a} + (DW+1)'(1);
        endcase
        res  = wide[DW-1:0];
        cy   = wide[DW];
        zero = (wide[DW-1:0] == '0);
        neg  = wide[DW-1];
    end

endmodule

// File: rtl/useq_regfile.sv
module useq_regfile #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    localparam int unsigned NW = 1 << AW;

    logic [NW-1:0][DW-1:0] rf_d;
    logic [NW-1:0][DW-1:0] rf_q;

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign rf_d[g] = (we && waddr == AW'(g)) ? wdata : rf_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata_a = rf_q[raddr_a];
    assign rdata_b = rf_q[raddr_b];

endmodule

// File: rtl/useq_seq.sv
module useq_seq
    import useq_pkg::*;
#(
    parameter int unsigned CSA = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           cs_we,
    input  logic [CSA-1:0] cs_addr,
    input  logic [UW-1:0]  cs_wdata,
    input  logic           f_zero,
    input  logic           f_neg,
    input  logic           f_cy,
    output uop_s           uop,
    output logic           mode,
    output logic [CSA-1:0] uaddr
);

    localparam int unsigned CSD = 1 << CSA;

    typedef struct packed {
        logic [CSA-1:0] uaddr;
    } seq_s;

    seq_s                  st_d, st_q;
    logic [CSD-1:0][UW-1:0] cs_d;
    logic [CSD-1:0][UW-1:0] cs_q;
    logic [UW-1:0]         word;
    logic                  flag;
    logic                  hit;
    logic                  rsvd_unused;

    for (genvar g = 0; g < CSD; g++) begin : g_store
        assign cs_d[g] = (cs_we && !start && cs_addr == CSA'(g)) ? cs_wdata : cs_q[g];
    end

    always_comb begin
        word = cs_q[st_q.uaddr];
        mode = word[MODE_B];
        case (cond_e'(word[COND_LO +: 2]))
            CND_START: flag = start;
            CND_ZERO:  flag = f_zero;
            CND_NEG:   flag = f_neg;
            default:   flag = f_cy;
        endcase
        hit = mode && (flag == word[CVAL_B]);

        st_d = st_q;
        st_d.uaddr = hit ? word[CSA-1:0] : st_q.uaddr + CSA'(1);

        uop.ra     = word[RA_LO +: RAW];
        uop.rb     = word[RB_LO +: RAW];
        uop.wc     = word[WC_LO +: RAW];
        uop.op     = alu_op_e'(word[OP_LO +: 2]);
        uop.ld_rf  = word[LDRF_B]  && !mode;
        uop.ld_out = word[LDOUT_B] && !mode;
        uop.ld_in  = word[LDIN_B]  && !mode;
        uop.sel_in = word[SEL_B];
        uop.done   = word[DONE_B]  && !mode;
    end

    assign rsvd_unused = word[0];
    assign uaddr = st_q.uaddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        cs_q <= cs_d;
    end

endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int unsigned DW  = 8,
    parameter int unsigned CSA = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic           done,
    input  logic           cs_we,
    input  logic [CSA-1:0] cs_addr,
    input  logic [UW-1:0]  cs_wdata
);

    typedef struct packed {
        logic [DW-1:0] rin;
        logic [DW-1:0] dout;
    } dp_s;

    dp_s            dp_d, dp_q;
    uop_s           uop;
    logic           mode;
    logic [CSA-1:0] uaddr;
    logic [DW-1:0]  rd_a, rd_b;
    logic [DW-1:0]  alu_res;
    logic [DW-1:0]  wr_data;
    logic           f_zero, f_neg, f_cy;

    useq_seq #(.CSA(CSA)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cs_we    (cs_we),
        .cs_addr  (cs_addr),
        .cs_wdata (cs_wdata),
        .f_zero   (f_zero),
        .f_neg    (f_neg),
        .f_cy     (f_cy),
        .uop      (uop),
        .mode     (mode),
        .uaddr    (uaddr)
    );

    useq_regfile #(.DW(DW), .AW(RAW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (uop.ld_rf),
        .waddr   (uop.wc),
        .wdata   (wr_data),
        .raddr_a (uop.ra),
        .raddr_b (uop.rb),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    useq_alu #(.DW(DW)) u_alu (
        .a    (rd_a),
        .b    (rd_b),
        .op   (uop.op),
        .res  (alu_res),
        .zero (f_zero),
        .neg  (f_neg),
        .cy   (f_cy)
    );

    assign wr_data = uop.sel_in ? dp_q.rin : alu_res;

    always_comb begin
        dp_d = dp_q;
        if (uop.ld_in) begin
            dp_d.rin = din;
        end
        if (uop.ld_out) begin
            dp_d.dout = alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign dout = dp_q.dout;
    assign done = uop.done;

endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
    parameter int unsigned DW  = 8,
    parameter int unsigned CSA = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           mode,
    input logic           done,
    input logic [CSA-1:0] uaddr,
    input logic [DW-1:0]  dout,
    input logic           ld_out,
    input logic           ld_rf,
    input logic           ld_in
);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (uaddr == '0 && dout == '0));

    // R8
    br_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode |-> !(done || ld_out || ld_rf || ld_in));

    // R7
    ctrl_step_chk: assert property (@(posedge clk) disable iff (rst)
        !mode |=> uaddr == CSA'($past(uaddr) + 1'b1));

    // R5
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_out |=> $stable(dout));

endmodule

bind useq_core useq_core_chk #(.DW(DW), .CSA(CSA)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .done   (done),
    .uaddr  (uaddr),
    .dout   (dout),
    .ld_out (uop.ld_out),
    .ld_rf  (uop.ld_rf),
    .ld_in  (uop.ld_in)
);

// File: tb/tb_useq_core.sv
module tb_useq_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  din = '0;
    logic        cs_we = 1'b0;
    logic [3:0]  cs_addr = '0;
    logic [17:0] cs_wdata = '0;
    logic [7:0]  dout;
    logic        done;

    int checks = 0;
    int fails  = 0;
    logic [17:0] prog [16];

    always #10 clk = ~clk;

    useq_core dut (
        .clk(clk), .rst(rst), .start(start), .din(din), .dout(dout), .done(done),
        .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata)
    );

    // ALU pairs {x, y}
    localparam logic [15:0] AVEC [6] = '{16'h1234, 16'hFF01, 16'h0000,
                                         16'h807F, 16'h0509, 16'hA55A};
    // branch cases {cond, value, op, x, y}
    localparam logic [20:0] BVEC [12] = '{
        {2'b00, 1'b1, 2'b00, 8'h00, 8'h00},
        {2'b00, 1'b0, 2'b00, 8'h00, 8'h00},
        {2'b01, 1'b1, 2'b01, 8'h05, 8'h05},
        {2'b01, 1'b1, 2'b00, 8'h03, 8'h04},
        {2'b01, 1'b0, 2'b10, 8'h07, 8'h07},
        {2'b10, 1'b1, 2'b01, 8'h02, 8'h03},
        {2'b10, 1'b0, 2'b00, 8'h10, 8'h20},
        {2'b11, 1'b1, 2'b00, 8'hF0, 8'h20},
        {2'b11, 1'b1, 2'b01, 8'h01, 8'h02},
        {2'b11, 1'b0, 2'b11, 8'hFF, 8'h00},
        {2'b11, 1'b1, 2'b10, 8'hFF, 8'hFF},
        {2'b10, 1'b1, 2'b11, 8'h7F, 8'h00}
    };

    function automatic logic [17:0] cw(input logic [2:0] a, input logic [2:0] b,
                                       input logic [2:0] c, input logic [1:0] op,
                                       input logic lrf, input logic lout, input logic lin,
                                       input logic sel, input logic dn);
        return {1'b0, a, b, c, op, lrf, lout, lin, sel, dn, 1'b0};
    endfunction

    function automatic logic [17:0] bw(input logic [1:0] cd, input logic v,
                                       input logic [2:0] b, input logic [1:0] op,
                                       input logic [3:0] t);
        return {1'b1, cd, v, b, 3'b000, op, 2'b11, t};
    endfunction

    function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
        case (op)
            2'b00:   return {1'b0, a} + {1'b0, b};
            2'b01:   return {1'b0, a} - {1'b0, b};
            2'b10:   return {1'b0, a ^ b};
            default: return {1'b0, a} + 9'd1;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_prog();
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            cs_addr  = 4'(i);
            cs_wdata = prog[i];
            cs_we    = 1'b1;
            tick();
        end
        cs_we = 1'b0;
    endtask

    task automatic run_p1(input logic [7:0] x, input logic [7:0] y,
                          input bit inject, input string tag);
        logic [8:0] m;
        din = x;
        start = 1'b1;
        if (inject) begin
            cs_we = 1'b1; cs_addr = 4'd6; cs_wdata = cw(1, 2, 0, 2'b10, 0, 1, 0, 0, 0);
        end
        tick();
        cs_we = 1'b0;
        tick();
        din = y;
        repeat (4) tick();
        m = model(2'b00, x, y); chk({tag, " add"}, dout, m[7:0]);
        tick();
        m = model(2'b01, x, y); chk({tag, " sub"}, dout, m[7:0]);
        tick();
        m = model(2'b10, x, y); chk({tag, " xor"}, dout, m[7:0]);
        tick();
        m = model(2'b11, x, y); chk({tag, " inc R1"}, dout, m[7:0]);
        chk("R6 done low mid-run", done, 0);
        tick();
        chk("R6 done bit", done, 1);
        start = 1'b0;
        tick();
        m = model(2'b01, x, y); chk("R4 sel0 write via R3", dout, m[7:0]);
        chk("R8 done low after", done, 0);
        tick();
        tick();
    endtask

    initial begin : wdog
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [8:0] m;
        logic [2:0] fa, bs;
        logic       flag, exp_taken;
        @(negedge clk);

        // program 1: operand intake, four ALU ops, mux paths
        prog[0]  = bw(2'b00, 0, 0, 0, 0);
        prog[1]  = cw(0, 0, 0, 0, 0, 0, 1, 0, 0);
        prog[2]  = cw(0, 0, 1, 0, 1, 0, 0, 1, 0);
        prog[3]  = cw(0, 0, 0, 0, 0, 0, 1, 0, 0);
        prog[4]  = cw(0, 0, 2, 0, 1, 0, 0, 1, 0);
        prog[5]  = cw(1, 2, 0, 2'b00, 0, 1, 0, 0, 0);
        prog[6]  = cw(1, 2, 0, 2'b01, 0, 1, 0, 0, 0);
        prog[7]  = cw(1, 2, 0, 2'b10, 0, 1, 0, 0, 0);
        prog[8]  = cw(1, 0, 0, 2'b11, 0, 1, 0, 0, 0);
        prog[9]  = cw(1, 2, 3, 2'b01, 1, 0, 0, 0, 0);
        prog[10] = cw(3, 0, 0, 2'b10, 0, 1, 0, 0, 1);
        prog[11] = bw(2'b00, 1, 0, 0, 11);
        prog[12] = bw(2'b00, 0, 0, 0, 0);
        for (int i = 13; i < 16; i++) prog[i] = '0;
        load_prog();
        rst = 1'b0;
        chk("R9 dout after reset", dout, 0);
        chk("R9 done after reset", done, 0);

        for (int v = 0; v < 6; v++) begin
            run_p1(AVEC[v][15:8], AVEC[v][7:0], 1'b0, "R2");
        end
        // R10: write attempted while start is high must not land
        run_p1(8'h21, 8'h03, 1'b1, "R10");

        // program 3: reset, increment and wrap
        for (int i = 0; i < 16; i++) prog[i] = '0;
        prog[0] = cw(0, 0, 0, 0, 0, 0, 0, 0, 1);
        load_prog();
        rst = 1'b0;
        chk("R9 dout cleared", dout, 0);
        chk("R9 start at 0", done, 1);
        tick();
        chk("R7 increment", done, 0);
        repeat (15) tick();
        chk("R7 wrap 15 to 0", done, 1);
        repeat (3) tick();
        chk("R7 away from 0", done, 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 mid-run reset to 0", done, 1);

        // program 2: branch conditions in the same cycle as their flags
        for (int v = 0; v < 12; v++) begin
            fa = BVEC[v][20:18];
            bs = fa ^ 3'b100;
            for (int i = 0; i < 16; i++) prog[i] = '0;
            prog[0]  = bw(2'b00, 0, 0, 0, 0);
            prog[1]  = cw(0, 0, 0, 0, 0, 0, 1, 0, 0);
            prog[2]  = cw(0, 0, fa, 0, 1, 0, 0, 1, 0);
            prog[3]  = cw(0, 0, 0, 0, 0, 0, 1, 0, 0);
            prog[4]  = cw(0, 0, bs, 0, 1, 0, 0, 1, 0);
            prog[5]  = bw(BVEC[v][20:19], BVEC[v][18], bs, BVEC[v][17:16], 4'd10);
            prog[10] = cw(0, 0, 0, 0, 0, 0, 0, 0, 1);
            load_prog();
            rst = 1'b0;
            din = BVEC[v][15:8];
            start = 1'b1;
            tick();
            tick();
            din = BVEC[v][7:0];
            repeat (3) tick();
            chk("R8 done forced low in branch", done, 0);
            tick();
            chk("R8 output load suppressed", dout, 0);
            m = model(BVEC[v][17:16], BVEC[v][15:8], BVEC[v][7:0]);
            case (BVEC[v][20:19])
                2'b00:   flag = 1'b1;
                2'b01:   flag = (m[7:0] == 8'h00);
                2'b10:   flag = m[7];
                default: flag = m[8];
            endcase
            exp_taken = (flag == BVEC[v][18]);
            chk("R7 R3 branch decision", done, int'(exp_taken));
            start = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule